// File: doc/BRIEF.md
# Nonvolatile Byte Access Controller

This block sits on a small processor's register bus and fronts an on-chip byte-wide nonvolatile array, here modelled as a synchronous byte RAM. Software loads a location register and a byte register, then writes the command register with one of two self-clearing strobe bits. A read strobe brings the addressed byte into the byte register within a few cycles, so software never needs to poll it. A write strobe commits the byte register to the array after a long, parameterised programming interval. The write bit stays visible as set for that whole interval so software can poll it.

Each accepted strobe also raises `cpu_stall`, a pipeline hold for the processor. It lasts two cycles for a write and four cycles for a read, and begins on the cycle after the command-register write. The sequencer has four states. IDLE goes to RD_ADDR on an accepted read strobe, and to WR_BUSY on an accepted write strobe. RD_ADDR always goes to RD_LOAD, and RD_LOAD always returns to IDLE. WR_BUSY stays put until its interval counter reaches zero, commits the byte and returns to IDLE. Strobes that arrive outside IDLE are dropped.

The block gives no protection against rewriting the location or byte register while a write is pending. The commit uses whatever those registers hold on the final busy cycle.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset, all four register slots read 0x00 and `cpu_stall` is low.
- R2: `bus_sel` picks the register. 0 is the location register, which holds the low AW bits of the written value and reads its upper bits as zero. 1 is the byte register. 2 is the command register, which reads as {6'b0, write bit at bit 1, read bit at bit 0}. 3 always reads 0x00. Writing only bits 7..2 of the command register starts nothing.
- R3: A command-register write with bit 1 set, made while IDLE, makes the write bit read 1 for exactly WR_CYCLES cycles, starting on the cycle after the bus write. Hardware then clears it.
- R4: An accepted write strobe holds `cpu_stall` high for exactly 2 cycles, starting on the cycle after the bus write.
- R5: A command-register write with bit 0 set and bit 1 clear, made while IDLE, makes the read bit read 1 for two cycles, after which hardware clears it. The byte register holds the addressed array byte from the third cycle on.
- R6: An accepted read strobe holds `cpu_stall` high for exactly 4 cycles, starting on the cycle after the bus write.
- R7: Once the write bit has cleared, a read of the same location returns the committed byte.
- R8: While a write is busy, any strobe is ignored. No stall is raised, the write bit stays set, the byte register is unchanged and the busy interval keeps its length.
- R9: When both strobe bits are written together while IDLE, only the write starts.
- R10: The committed location and byte are the register contents on the last busy cycle. Rewriting either register during the busy interval redirects the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select (0 location, 1 byte, 2 command) |
| bus_wr | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected slot |
| cpu_stall | output | 1 | Pipeline hold for the processor |

## Verification
The hardest case to reach is a strobe that lands inside the write busy interval. It must neither restart the interval nor raise a stall, nor load the byte register. The bench opens a write, lets the two stall cycles pass, and then issues a read strobe and a combined strobe in the middle of WR_BUSY. It tracks the interval length with its own cycle counter, starting from the edge that captured the original strobe. A second hard case is redirecting a pending write. The bench rewrites both registers mid-interval, then reads back the old location and the new one.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_LOAD,
        ST_WR_BUSY
    } nvm_state_t;

    localparam logic [1:0] SEL_LOC  = 2'd0;
    localparam logic [1:0] SEL_BYTE = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;

    localparam int CMD_WR_BIT = 1;
    localparam int CMD_RD_BIT = 0;

endpackage

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/nvm_stall_timer.sv
module nvm_stall_timer #(
    parameter int RD_STALL = 4,
    parameter int WR_STALL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    output logic stall
);
    localparam int MAXS = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int SW   = $clog2(MAXS + 1);

    logic [SW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_wr) begin
            remain <= SW'(WR_STALL);
        end else if (start_rd) begin
            remain <= SW'(RD_STALL);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign stall = (remain != '0);

endmodule

// File: rtl/nvm_ctl_fsm.sv
module nvm_ctl_fsm
    import nvm_pkg::*;
#(
    parameter int WR_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_wr,
    input  logic strobe_rd,
    output logic accept_wr,
    output logic accept_rd,
    output logic wr_bit,
    output logic rd_bit,
    output logic mem_we,
    output logic data_load
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    nvm_state_t state, state_nx;
    logic [CW-1:0] wait_cnt;
    logic          wait_done;

    assign accept_wr = (state == ST_IDLE) && strobe_wr;
    assign accept_rd = (state == ST_IDLE) && strobe_rd && !strobe_wr;
    assign wait_done = (wait_cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // busy interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (accept_wr) begin
            wait_cnt <= CW'(WR_CYCLES - 1);
        end else if (state == ST_WR_BUSY && !wait_done) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_wr) begin
                    state_nx = ST_WR_BUSY;
                end else if (accept_rd) begin
                    state_nx = ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: state_nx = ST_RD_LOAD;
            ST_RD_LOAD: state_nx = ST_IDLE;
            ST_WR_BUSY: begin
                if (wait_done) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_bit    = 1'b0;
        rd_bit    = 1'b0;
        mem_we    = 1'b0;
        data_load = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RD_ADDR: rd_bit = 1'b1;
            ST_RD_LOAD: begin
                rd_bit    = 1'b1;
                data_load = 1'b1;
            end
            ST_WR_BUSY: begin
                wr_bit = 1'b1;
                mem_we = wait_done;
            end
        endcase
    end

endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int AW        = 6,
    parameter int WR_CYCLES = 10000,
    parameter int RD_STALL  = 4,
    parameter int WR_STALL  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_stall
);
    logic [AW-1:0] loc_q;
    logic [7:0]    byte_q;
    logic [7:0]    array_q;
    logic [7:0]    loc_view;
    logic          cmd_write;
    logic          strobe_wr, strobe_rd;
    logic          accept_wr, accept_rd;
    logic          wr_bit, rd_bit;
    logic          mem_we, data_load;

    assign cmd_write = bus_wr && (bus_sel == SEL_CMD);
    assign strobe_wr = cmd_write && bus_wdata[CMD_WR_BIT];
    assign strobe_rd = cmd_write && bus_wdata[CMD_RD_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q <= '0;
        end else if (bus_wr && bus_sel == SEL_LOC) begin
            loc_q <= bus_wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (data_load) begin
            byte_q <= array_q;
        end else if (bus_wr && bus_sel == SEL_BYTE) begin
            byte_q <= bus_wdata;
        end
    end

    always_comb begin
        loc_view         = '0;
        loc_view[AW-1:0] = loc_q;
    end

    always_comb begin
        case (bus_sel)
            SEL_LOC:  bus_rdata = loc_view;
            SEL_BYTE: bus_rdata = byte_q;
            SEL_CMD:  bus_rdata = {6'b0, wr_bit, rd_bit};
            default:  bus_rdata = 8'h00;
        endcase
    end

    nvm_ctl_fsm #(
        .WR_CYCLES(WR_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_wr (strobe_wr),
        .strobe_rd (strobe_rd),
        .accept_wr (accept_wr),
        .accept_rd (accept_rd),
        .wr_bit    (wr_bit),
        .rd_bit    (rd_bit),
        .mem_we    (mem_we),
        .data_load (data_load)
    );

    nvm_stall_timer #(
        .RD_STALL(RD_STALL),
        .WR_STALL(WR_STALL)
    ) u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (accept_rd),
        .start_wr (accept_wr),
        .stall    (cpu_stall)
    );

    nvm_byte_array #(
        .AW(AW)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (loc_q),
        .wdata (byte_q),
        .raddr (loc_q),
        .rdata (array_q)
    );

endmodule

// File: rtl/nvm_access_ctrl_sva.sv
module nvm_access_ctrl_sva #(
    parameter int MAX_STALL = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       cpu_stall,
    input logic       wr_bit,
    input logic       rd_bit
);
    logic [3:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!cpu_stall) begin
            run_len <= '0;
        end else if (run_len != 4'hF) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2: unused command bits read as zero
    assert_cmd_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd2) |-> (bus_rdata[7:2] == 6'b0));

    // R4 / R6: a stall only begins after a strobe write
    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(bus_wr && bus_sel == 2'd2 && (bus_wdata[1] || bus_wdata[0])));

    // R4: starting a write raises the stall together with the busy bit
    assert_wr_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_bit) |-> cpu_stall);

    // R6: no stall run is longer than the read stall
    assert_stall_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 4'(MAX_STALL));

    // R5: the read bit stays up for exactly two cycles
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_bit) |=> rd_bit);
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bit && $past(rd_bit)) |=> !rd_bit);

    // R8: nothing starts a stall while a write is busy
    assert_wr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit |=> !$rose(cpu_stall));

    // R9: read and write never run together
    assert_bits_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_bit && rd_bit));

endmodule

bind nvm_access_ctrl nvm_access_ctrl_sva #(
    .MAX_STALL(RD_STALL)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_stall (cpu_stall),
    .wr_bit    (wr_bit),
    .rd_bit    (rd_bit)
);

// File: tb/nvm_access_ctrl_test.sv
module nvm_access_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WRC        = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_sel;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       cpu_stall;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvm_access_ctrl #(.AW(6), .WR_CYCLES(WRC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_stall (cpu_stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        bus_sel   = sel;
        bus_wdata = val;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(input int c0, output int busy);
        logic [7:0] v;
        peek(2'd2, v);
        for (int g = 0; g < 4 * WRC && v[1]; g++) begin
            @(negedge clk);
            peek(2'd2, v);
        end
        busy = cyc - c0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] v);
        bus_write(2'd0, a);
        bus_write(2'd2, 8'h01);
        repeat (4) @(negedge clk);
        peek(2'd1, v);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        int c0, busy;
        bus_write(2'd0, a);
        bus_write(2'd1, d);
        bus_write(2'd2, 8'h02);
        c0 = cyc;
        wait_idle(c0, busy);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            chk("R1 reset register value", v, 0);
        end
        chk("R1 reset stall", cpu_stall, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        bus_write(2'd0, 8'hFF);
        peek(2'd0, v);
        chk("R2 location width mask", v, 8'h3F);
        bus_write(2'd1, 8'hA5);
        peek(2'd1, v);
        chk("R2 byte register", v, 8'hA5);
        peek(2'd3, v);
        chk("R2 slot 3 reads zero", v, 0);
        bus_write(2'd2, 8'hFC);
        peek(2'd2, v);
        chk("R2 command pad bits", v, 0);
        chk("R2 no stall from pad bits", cpu_stall, 0);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int c0, busy;
        bus_write(2'd0, 8'd5);
        bus_write(2'd1, 8'h3C);
        bus_write(2'd2, 8'h02);
        c0 = cyc;
        peek(2'd2, v);
        chk("R3 write bit set", v, 8'h02);
        chk("R4 stall cycle 1", cpu_stall, 1);
        @(negedge clk);
        chk("R4 stall cycle 2", cpu_stall, 1);
        @(negedge clk);
        chk("R4 stall ends after 2", cpu_stall, 0);
        wait_idle(c0, busy);
        chk("R3 write busy length", busy, WRC);
    endtask

    task automatic t_read;
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'd5);
        bus_write(2'd2, 8'h01);
        for (int i = 0; i < 5; i++) begin
            peek(2'd2, v);
            chk("R5 read bit timing", v[0], (i < 2) ? 1 : 0);
            chk("R6 read stall timing", cpu_stall, (i < 4) ? 1 : 0);
            if (i == 2) begin
                peek(2'd1, v);
                chk("R7 read after write data", v, 8'h3C);
            end
            if (i < 4) @(negedge clk);
        end
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        int c0, busy;
        bus_write(2'd0, 8'd9);
        bus_write(2'd1, 8'h11);
        bus_write(2'd2, 8'h02);
        c0 = cyc;
        repeat (3) @(negedge clk);
        bus_write(2'd2, 8'h01);
        chk("R8 no stall for read while busy", cpu_stall, 0);
        peek(2'd2, v);
        chk("R8 command while busy", v, 8'h02);
        peek(2'd1, v);
        chk("R8 byte register untouched", v, 8'h11);
        bus_write(2'd2, 8'h03);
        chk("R8 no stall for both while busy", cpu_stall, 0);
        wait_idle(c0, busy);
        chk("R8 busy length unchanged", busy, WRC);
        do_read(8'd9, v);
        chk("R7 stored byte at 9", v, 8'h11);
    endtask

    task automatic t_both;
        logic [7:0] v;
        int c0, busy;
        bus_write(2'd0, 8'd12);
        bus_write(2'd1, 8'h5A);
        bus_write(2'd2, 8'h03);
        c0 = cyc;
        peek(2'd2, v);
        chk("R9 only write bit set", v, 8'h02);
        chk("R9 stall cycle 1", cpu_stall, 1);
        @(negedge clk);
        @(negedge clk);
        chk("R9 write stall length", cpu_stall, 0);
        wait_idle(c0, busy);
        chk("R9 busy length", busy, WRC);
        do_read(8'd12, v);
        chk("R9 write committed", v, 8'h5A);
    endtask

    task automatic t_rewrite;
        logic [7:0] v;
        int c0, busy;
        do_write(8'd10, 8'h55);
        bus_write(2'd0, 8'd10);
        bus_write(2'd1, 8'h77);
        bus_write(2'd2, 8'h02);
        c0 = cyc;
        bus_write(2'd0, 8'd11);
        bus_write(2'd1, 8'h88);
        wait_idle(c0, busy);
        do_read(8'd11, v);
        chk("R10 redirected location", v, 8'h88);
        do_read(8'd10, v);
        chk("R10 original location kept", v, 8'h55);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_sel   = 2'd0;
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_write;
        t_read;
        t_ignore;
        t_both;
        t_rewrite;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule